// File: doc/BRIEF.md
# Two-Level Lookahead 64-bit Adder

This block adds two 64-bit operands and a single carry-in. It returns a 64-bit sum and a carry-out, and it has no clock, so the result settles within one combinational path. The carries are never passed from one slice to the next in a chain. They are worked out by lookahead at three levels.

The lowest level is a 4-bit slice. Each slice forms a propagate (a XOR b) and a generate (a AND b) for every bit. It resolves the carries into its upper bits from its own carry-in, and it reports a group propagate and a group generate. Four slices and one lookahead unit make a 16-bit block. Four blocks report their block propagate and block generate to a second lookahead unit of the same design. That unit sends each block its carry-in and produces the final carry-out.

The slice width and the fan-in of a lookahead unit are parameters. The adder width must equal the slice width times the fan-in squared.

Top module: `cla_adder64`

## Requirements
- R1: {cout, sum} equals the 65-bit value a + b + cin for every operand pair and both values of cin.
- R2: A slice's group propagate is 1 exactly when every bit in the slice has a different value in a and b. A carry arriving at such a slice passes straight through it.
- R3: A slice's group generate is G3 + G2·P3 + G1·P2·P3 + G0·P1·P2·P3, built from the bit generate and propagate terms. A generate in bit 3 of a slice carries into the next slice.
- R4: Inside a slice, the carry into bit i comes from flattened lookahead on the slice carry-in. Each sum bit is the bit propagate XOR the carry into that bit.
- R5: A carry produced or passed by slice k of a block reaches slice k+1 of the same block through the first-level lookahead unit.
- R6: The second-level unit gives block k the carry produced by bits 0 to 16k-1 together with cin. Its top carry drives cout, and cout equals block generate OR (block propagate AND cin).
- R7: All-ones plus one with cin clear gives a zero sum with cout set.
- R8: All-ones plus zero with cin set gives a zero sum with cout set. This is a full propagate chain with no generate anywhere.
- R9: Zero plus zero with cin clear gives a zero sum with cout clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 64 | First operand |
| b | input | 64 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 64 | Low 64 bits of a + b + cin |
| cout | output | 1 | Carry out of bit 63 |

## Verification
The bench aims at the places where a lookahead term can be lost.

| Case | What it exercises | What a faulty design does |
|------|-------------------|---------------------|
| A carry entering at a 4-bit boundary | The slice carry path | A design that drops a slice carry clears a nibble that should be set. |
| A carry entering at a 16-bit boundary | The block carry path | A broken block carry loses a 16-bit boundary carry, so the upper half of the result stays low. |
| Full-width propagate chains | The lookahead product terms | A missing propagate factor fails to return a zero sum with cout set. |
| Alternating patterns with cin set and clear | The cin product term | A fault in the cin term shows up as a difference of one in the result or in cout. |

Random operands cover the remaining term combinations.

// File: rtl/cla_pkg.sv
package cla_pkg;
   localparam int unsigned SLICE_W = 4;
   localparam int unsigned FANIN   = 4;
   localparam int unsigned BLOCK_W = SLICE_W * FANIN;
   localparam int unsigned ADD_W   = BLOCK_W * FANIN;
endpackage

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] p,
   input  logic [N-1:0] g,
   input  logic         ci,
   output logic [N-1:0] c,
   output logic         co,
   output logic         pg,
   output logic         gg
);
   generate
      if (N < 2) begin : g_bad_n
         $error("cla_lookahead: N must be at least 2");
      end
   endgenerate

   logic [N:0] carr;

   // Flattened sum-of-products for every carry, no chained term
   always_comb begin
      carr[0] = ci;
      for (int k = 1; k <= N; k++) begin
         logic acc;
         logic chain;
         chain = ci;
         for (int m = 0; m < k; m++) chain = chain & p[m];
         acc = chain;
         for (int j = 0; j < k; j++) begin
            logic term;
            term = g[j];
            for (int m = j + 1; m < k; m++) term = term & p[m];
            acc = acc | term;
         end
         carr[k] = acc;
      end
   end

   always_comb begin
      logic acc;
      acc = 1'b0;
      for (int j = 0; j < N; j++) begin
         logic term;
         term = g[j];
         for (int m = j + 1; m < N; m++) term = term & p[m];
         acc = acc | term;
      end
      gg = acc;
   end

   assign pg = &p;
   assign c  = carr[N-1:0];
   assign co = carr[N];

   // R6 / R3: the flattened top carry must agree with group terms
   always_comb begin
      a_r6_group_carry: assert (co == (gg | (pg & ci)))
         else $error("lookahead top carry disagrees with group terms");
   end
endmodule

// File: rtl/cla_slice.sv
module cla_slice #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         ci,
   output logic [W-1:0] sum,
   output logic         pg,
   output logic         gg
);
   logic [W-1:0] bp;
   logic [W-1:0] bg;
   logic [W-1:0] bc;
   logic         co;

   assign bp = a ^ b;
   assign bg = a & b;

   cla_lookahead #(.N(W)) u_la (
      .p (bp),
      .g (bg),
      .ci(ci),
      .c (bc),
      .co(co),
      .pg(pg),
      .gg(gg)
   );

   genvar i;
   generate
      for (i = 0; i < W; i++) begin : g_sum
         assign sum[i] = bp[i] ^ bc[i];
      end
   endgenerate

   logic [W:0] ref_v;
   assign ref_v = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};

   always_comb begin
      a_r2_group_prop: assert (pg == ((a ^ b) == {W{1'b1}}))
         else $error("slice group propagate wrong");
      a_r4_slice_sum: assert ({co, sum} == ref_v)
         else $error("slice sum/carry wrong");
   end
endmodule

// File: rtl/cla_block.sv
module cla_block #(
   parameter int unsigned SW = 4,
   parameter int unsigned N  = 4
) (
   input  logic [SW*N-1:0] a,
   input  logic [SW*N-1:0] b,
   input  logic            ci,
   output logic [SW*N-1:0] sum,
   output logic            pg,
   output logic            gg
);
   localparam int unsigned BW = SW * N;

   logic [N-1:0] sp;
   logic [N-1:0] sg;
   logic [N-1:0] sc;
   logic         co;

   genvar k;
   generate
      for (k = 0; k < N; k++) begin : g_slice
         cla_slice #(.W(SW)) u_slice (
            .a  (a[k*SW +: SW]),
            .b  (b[k*SW +: SW]),
            .ci (sc[k]),
            .sum(sum[k*SW +: SW]),
            .pg (sp[k]),
            .gg (sg[k])
         );
      end
   endgenerate

   cla_lookahead #(.N(N)) u_la1 (
      .p (sp),
      .g (sg),
      .ci(ci),
      .c (sc),
      .co(co),
      .pg(pg),
      .gg(gg)
   );

   logic [BW:0] ref_v;
   assign ref_v = {1'b0, a} + {1'b0, b} + {{BW{1'b0}}, ci};

   always_comb begin
      a_r5_block_sum: assert ({co, sum} == ref_v)
         else $error("block sum/carry wrong");
   end
endmodule

// File: rtl/cla_adder64.sv
module cla_adder64
   import cla_pkg::*;
#(
   parameter int unsigned SW    = SLICE_W,
   parameter int unsigned N     = FANIN,
   parameter int unsigned WIDTH = ADD_W
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   localparam int unsigned BW = SW * N;

   generate
      if (WIDTH != BW * N) begin : g_bad_width
         $error("cla_adder64: WIDTH must equal SW*N*N");
      end
   endgenerate

   logic [N-1:0] bp;
   logic [N-1:0] bg;
   logic [N-1:0] bc;
   logic         tp;
   logic         tg;

   genvar k;
   generate
      for (k = 0; k < N; k++) begin : g_block
         cla_block #(.SW(SW), .N(N)) u_blk (
            .a  (a[k*BW +: BW]),
            .b  (b[k*BW +: BW]),
            .ci (bc[k]),
            .sum(sum[k*BW +: BW]),
            .pg (bp[k]),
            .gg (bg[k])
         );
         if (k > 0) begin : g_chk
            localparam int unsigned LO = k * BW;
            logic [LO:0] part;
            assign part = {1'b0, a[LO-1:0]} + {1'b0, b[LO-1:0]} + {{LO{1'b0}}, cin};
            always_comb begin
               a_r6_block_cin: assert (bc[k] == part[LO])
                  else $error("block carry-in wrong");
            end
         end
      end
   endgenerate

   cla_lookahead #(.N(N)) u_la2 (
      .p (bp),
      .g (bg),
      .ci(cin),
      .c (bc),
      .co(cout),
      .pg(tp),
      .gg(tg)
   );

   logic [WIDTH:0] ref_v;
   assign ref_v = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

   always_comb begin
      a_r1_total: assert ({cout, sum} == ref_v)
         else $error("adder result wrong");
      a_r6_cout_terms: assert (cout == (tg | (tp & cin)))
         else $error("cout disagrees with block terms");
   end
endmodule

// File: tb/cla_adder64_test.sv
module cla_adder64_test;
   logic        clk = 1'b0;
   always #2 clk = ~clk;

   logic [63:0] a, b, sum;
   logic        cin, cout;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done  = 1'b0;

   cla_adder64 uut (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

   localparam int NV = 13;
   localparam logic [63:0] VA [NV] = '{
      64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
      64'hAAAA_AAAA_AAAA_AAAA, 64'hAAAA_AAAA_AAAA_AAAA,
      64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555,
      64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_000F,
      64'h7, 64'h0000_FFFF_FFFF_FFFF, 64'h8, 64'h00F0};
   localparam logic [63:0] VB [NV] = '{
      64'h0, 64'h1, 64'h0,
      64'h5555_5555_5555_5555, 64'h5555_5555_5555_5555,
      64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555,
      64'h1, 64'h1, 64'h1, 64'h1, 64'h8, 64'h0010};
   localparam logic VC [NV] = '{0, 0, 1, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0};
   localparam logic [64:0] VE [NV] = '{
      65'h0, 65'h1_0000_0000_0000_0000, 65'h1_0000_0000_0000_0000,
      65'h0_FFFF_FFFF_FFFF_FFFF, 65'h1_0000_0000_0000_0000,
      65'h1_5555_5555_5555_5554, 65'h0_AAAA_AAAA_AAAA_AAAB,
      65'h1_0000, 65'h10, 65'h8, 65'h0_0001_0000_0000_0000,
      65'h10, 65'h100};
   localparam logic [15:0] VT [NV] = '{
      "R9", "R7", "R8", "R2", "R6", "R3", "R1",
      "R6", "R5", "R4", "R6", "R3", "R5"};

   task automatic apply(input logic [63:0] xa, input logic [63:0] xb, input logic xc);
      @(posedge clk);
      #1;
      a = xa; b = xb; cin = xc;
      @(negedge clk);
   endtask

   task automatic check(input logic [15:0] tag, input logic [64:0] exp);
      n_chk++;
      if ({cout, sum} !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h (a=%h b=%h cin=%b)",
                  tag, {cout, sum}, exp, a, b, cin);
      end
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      a = '0; b = '0; cin = 1'b0;
      // R9: quiescent state with zero inputs
      apply(64'h0, 64'h0, 1'b0);
      check("R9", 65'h0);

      for (int i = 0; i < NV; i++) begin
         apply(VA[i], VB[i], VC[i]);
         check(VT[i], VE[i]);
      end

      // R6: carry entering each block boundary from below
      for (int k = 1; k < 4; k++) begin
         logic [63:0] lo;
         lo = (64'h1 << (16 * k)) - 64'h1;
         apply(lo, 64'h0, 1'b1);
         check("R6", {1'b0, 64'h1 << (16 * k)});
      end

      // R5: carry through each slice boundary inside block 2
      for (int s = 1; s < 4; s++) begin
         logic [63:0] lo;
         lo = ((64'h1 << (4 * s)) - 64'h1) << 32;
         apply(lo, 64'h1 << 32, 1'b0);
         check("R5", {1'b0, 64'h1 << (32 + 4 * s)});
      end

      // R1: random operands with cin both ways, behavioural reference
      for (int i = 0; i < 400; i++) begin
         logic [63:0] ra, rb;
         logic        rc;
         ra = {$urandom, $urandom};
         rb = {$urandom, $urandom};
         rc = 1'(i & 1);
         apply(ra, rb, rc);
         check("R1", {1'b0, ra} + {1'b0, rb} + {64'h0, rc});
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule